// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-rank SDRAM from power-on to a usable state. Once reset is released it drives the command pins only: clock enable, the four active-low strobes, the bank address and the address bus. It holds the device quiet for a stabilization period. It then closes every bank with one precharge and gives the device a fixed number of auto-refresh commands. Last, it loads the mode register with the configured burst length, burst type and CAS latency. A memory controller holds off its own traffic until `init_done` goes high.

All waits are computed from a clock-frequency parameter in MHz. The stabilization period comes from a microsecond parameter. The precharge and refresh recovery times come from nanosecond parameters, rounded up to whole cycles with a minimum of one. The mode-register recovery time is given directly in cycles. The outputs are registered. Any reset restarts the whole bring-up from the beginning.

Top module: `sdram_bringup`

## Requirements
- R1: While reset is asserted, CKE is 1, the strobes {cs_n,ras_n,cas_n,we_n} read 0111 (NOP), ba and addr are all zero, and init_done is 0.
- R2: After reset is released, exactly STABLE_CYC = STABLE_US*CLK_MHZ cycles of NOP are driven. With 200 us at 100 MHz this is 20000 cycles. The precharge appears in the next cycle.
- R3: The precharge is encoded as strobes 0010, with addr bit 10 high and every other addr and ba bit zero.
- R4: The first auto-refresh appears TRP_CYC cycles after the precharge cycle. Here TRP_CYC = ceil(TRP_NS*CLK_MHZ/1000), with a minimum of 1.
- R5: Exactly REFRESH_COUNT auto-refreshes are issued, 8 by default. Each is encoded as strobes 0001. Consecutive refreshes are TRC_CYC = ceil(TRC_NS*CLK_MHZ/1000) cycles apart, with a minimum of 1.
- R6: The mode register set, encoded as strobes 0000 with ba zero, appears TRC_CYC cycles after the last refresh.
- R7: During the mode register set, addr[2:0] holds the burst-length code (1→0, 2→1, 4→2, 8→3), addr[3] holds the burst type and addr[6:4] holds the CAS latency. All other addr bits are zero.
- R8: init_done rises exactly TRSC_CYC cycles after the mode register set cycle. Once high it stays high until reset, and no command other than NOP follows.
- R9: CKE stays high and the strobes read NOP in every cycle that is not one of the listed command cycles.
- R10: A reset asserted at any point of the sequence returns the outputs to the R1 state. After release, the full sequence restarts with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | output | 1 | Clock enable to the device, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus; carries the all-bank bit and the mode word |
| init_done | output | 1 | High once bring-up has completed |

## Verification
The only input is reset, so the stimulus is the timing of reset. Uninterrupted bring-ups compare every cycle's strobes, address and done flag against a schedule computed from the parameters. This separates off-by-one errors in the quiet window, the recovery gaps and the refresh count. Resets of random length, applied at random points, show that no state survives a reset. Directed aborts on the last quiet cycle, in the middle of the refreshes and during the mode-register recovery show that the restart always begins with a full stabilization wait and not from a partly consumed counter.

// File: rtl/sdram_bringup_pkg.sv
package sdram_bringup_pkg;

    // Strobe encodings on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } cmd_e;

    typedef enum logic [2:0] {
        ST_STABLE   = 3'd0,
        ST_PRE_WAIT = 3'd1,
        ST_REF_WAIT = 3'd2,
        ST_MRS_WAIT = 3'd3,
        ST_DONE     = 3'd4
    } phase_e;

    // Round a nanosecond interval up to whole clock cycles, at least one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    // Burst-length field code; unsupported lengths map to full page
    function automatic int unsigned burst_code(input int unsigned len);
        case (len)
            1:       return 0;
            2:       return 1;
            4:       return 2;
            8:       return 3;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/bringup_timer.sv
module bringup_timer #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned RESET_VAL = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_W'(RESET_VAL);
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/bringup_refcnt.sv
module bringup_refcnt #(
    parameter int unsigned COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic none_left
);
    localparam int unsigned RW = $clog2(COUNT + 1);

    logic [RW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (step && left_q != '0)
            left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= RW'(COUNT);
        else
            left_q <= left_d;
    end

    assign none_left = (left_q == '0);
endmodule

// File: rtl/bringup_modeword.sv
module bringup_modeword #(
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned BURST_LEN   = 4,
    parameter bit          BURST_INTLV = 1'b0,
    parameter int unsigned CAS_LAT     = 3,
    parameter int unsigned ALLBANK_BIT = 10
) (
    output logic [ADDR_W-1:0] mode_word,
    output logic [ADDR_W-1:0] pre_word
);
    import sdram_bringup_pkg::*;

    localparam logic [2:0] BL_FIELD = 3'(burst_code(BURST_LEN));
    localparam logic [2:0] CL_FIELD = 3'(CAS_LAT);

    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = BL_FIELD;
        mode_word[3]   = BURST_INTLV;
        mode_word[6:4] = CL_FIELD;
    end

    always_comb begin
        pre_word              = '0;
        pre_word[ALLBANK_BIT] = 1'b1;
    end
endmodule

// File: rtl/sdram_bringup.sv
module sdram_bringup #(
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned STABLE_US   = 200,
    parameter int unsigned TRP_NS      = 20,
    parameter int unsigned TRC_NS      = 70,
    parameter int unsigned TRSC_CLK    = 2,
    parameter int unsigned REFRESH_CNT = 8,
    parameter int unsigned BURST_LEN   = 4,
    parameter bit          BURST_INTLV = 1'b0,
    parameter int unsigned CAS_LAT     = 3,
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned BANK_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    import sdram_bringup_pkg::*;

    localparam int unsigned STABLE_CYC = at_least_one(STABLE_US * CLK_MHZ);
    localparam int unsigned TRP_CYC    = ns_to_cyc(TRP_NS, CLK_MHZ);
    localparam int unsigned TRC_CYC    = ns_to_cyc(TRC_NS, CLK_MHZ);
    localparam int unsigned TRSC_CYC   = at_least_one(TRSC_CLK);
    localparam int unsigned GAP_MAX    = (TRP_CYC > TRC_CYC)
                                       ? ((TRP_CYC > TRSC_CYC) ? TRP_CYC : TRSC_CYC)
                                       : ((TRC_CYC > TRSC_CYC) ? TRC_CYC : TRSC_CYC);
    localparam int unsigned WAIT_MAX   = (STABLE_CYC > GAP_MAX) ? STABLE_CYC : GAP_MAX;
    localparam int unsigned CNT_W      = $clog2(WAIT_MAX + 1);

    typedef struct packed {
        phase_e            phase;
        logic              cke;
        cmd_e              cmd;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        phase: ST_STABLE,
        cke:   1'b1,
        cmd:   CMD_NOP,
        ba:    '0,
        addr:  '0,
        done:  1'b0
    };

    ctl_t ctl_d, ctl_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             ref_step;
    logic             ref_none_left;
    logic [ADDR_W-1:0] mode_word;
    logic [ADDR_W-1:0] pre_word;

    bringup_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (STABLE_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    bringup_refcnt #(
        .COUNT (REFRESH_CNT)
    ) u_refcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (ref_step),
        .none_left (ref_none_left)
    );

    bringup_modeword #(
        .ADDR_W      (ADDR_W),
        .BURST_LEN   (BURST_LEN),
        .BURST_INTLV (BURST_INTLV),
        .CAS_LAT     (CAS_LAT),
        .ALLBANK_BIT (10)
    ) u_modeword (
        .mode_word (mode_word),
        .pre_word  (pre_word)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.cke  = 1'b1;
        ctl_d.cmd  = CMD_NOP;
        ctl_d.ba   = '0;
        ctl_d.addr = '0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        ref_step   = 1'b0;

        case (ctl_q.phase)
            ST_STABLE: begin
                if (tmr_expired) begin
                    ctl_d.cmd   = CMD_PRE;
                    ctl_d.addr  = pre_word;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(TRP_CYC - 1);
                    ctl_d.phase = ST_PRE_WAIT;
                end
            end
            ST_PRE_WAIT: begin
                if (tmr_expired) begin
                    ctl_d.cmd   = CMD_REF;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(TRC_CYC - 1);
                    ref_step    = 1'b1;
                    ctl_d.phase = ST_REF_WAIT;
                end
            end
            ST_REF_WAIT: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (!ref_none_left) begin
                        ctl_d.cmd = CMD_REF;
                        tmr_val   = CNT_W'(TRC_CYC - 1);
                        ref_step  = 1'b1;
                    end else begin
                        ctl_d.cmd   = CMD_MRS;
                        ctl_d.addr  = mode_word;
                        tmr_val     = CNT_W'(TRSC_CYC - 1);
                        ctl_d.phase = ST_MRS_WAIT;
                    end
                end
            end
            ST_MRS_WAIT: begin
                if (tmr_expired) begin
                    ctl_d.done  = 1'b1;
                    ctl_d.phase = ST_DONE;
                end
            end
            ST_DONE: begin
                ctl_d.done = 1'b1;
            end
            default: begin
                ctl_d.phase = ST_STABLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= CTL_RESET;
        else
            ctl_q <= ctl_d;
    end

    assign cke       = ctl_q.cke;
    assign cs_n      = ctl_q.cmd[3];
    assign ras_n     = ctl_q.cmd[2];
    assign cas_n     = ctl_q.cmd[1];
    assign we_n      = ctl_q.cmd[0];
    assign ba        = ctl_q.ba;
    assign addr      = ctl_q.addr;
    assign init_done = ctl_q.done;
endmodule

// File: rtl/sdram_bringup_chk.sv
module sdram_bringup_chk #(
    parameter int unsigned STABLE_CYC  = 20000,
    parameter int unsigned REFRESH_CNT = 8,
    parameter int unsigned BURST_LEN   = 4,
    parameter bit          BURST_INTLV = 1'b0,
    parameter int unsigned CAS_LAT     = 3,
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned BANK_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);
    localparam int unsigned SW = $clog2(STABLE_CYC + 2);
    localparam int unsigned RW = $clog2(REFRESH_CNT + 1);
    localparam logic [ADDR_W-1:0] EXP_MODE =
        ADDR_W'({3'(CAS_LAT), BURST_INTLV, 3'((BURST_LEN > 8) ? 7 : $clog2(BURST_LEN))});
    localparam logic [ADDR_W-1:0] EXP_PRE = ADDR_W'(1) << 10;

    logic [3:0]    cmd;
    logic [SW-1:0] since_rst;
    logic [RW-1:0] refs_seen;
    logic          mrs_seen;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            refs_seen <= '0;
            mrs_seen  <= 1'b0;
        end else begin
            if (since_rst <= SW'(STABLE_CYC))
                since_rst <= since_rst + 1'b1;
            if (cmd == 4'b0001 && refs_seen < RW'(REFRESH_CNT))
                refs_seen <= refs_seen + 1'b1;
            if (cmd == 4'b0000)
                mrs_seen <= 1'b1;
        end
    end

    a_r9_cke_high: assert property (@(posedge clk) disable iff (!rst_n) cke == 1'b1);

    a_r9_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0111) || (cmd == 4'b0010) || (cmd == 4'b0001) || (cmd == 4'b0000));

    a_r2_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 4'b0111) |-> (since_rst > SW'(STABLE_CYC)));

    a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> (addr == EXP_PRE && ba == '0 && refs_seen == '0));

    a_r5_refresh_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0001) |-> (refs_seen < RW'(REFRESH_CNT)));

    a_r6_mrs_after_refs: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> (refs_seen == RW'(REFRESH_CNT) && ba == '0 && !mrs_seen));

    a_r7_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> (addr == EXP_MODE));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == 4'b0111));

    a_r8_done_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> mrs_seen);

endmodule

bind sdram_bringup sdram_bringup_chk #(
    .STABLE_CYC  (STABLE_CYC),
    .REFRESH_CNT (REFRESH_CNT),
    .BURST_LEN   (BURST_LEN),
    .BURST_INTLV (BURST_INTLV),
    .CAS_LAT     (CAS_LAT),
    .ADDR_W      (ADDR_W),
    .BANK_W      (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/sim_sdram_bringup.sv
`timescale 1ns/1ps
module sim_sdram_bringup;
    localparam int unsigned MHZ   = 50;
    localparam int unsigned ST_US = 200;
    localparam int unsigned RP_NS = 20;
    localparam int unsigned RC_NS = 70;
    localparam int unsigned RSC   = 2;
    localparam int unsigned NREF  = 8;
    localparam int unsigned BL    = 4;
    localparam int unsigned CL    = 3;
    localparam int unsigned AW    = 13;
    localparam int unsigned BW    = 2;

    function automatic int unsigned up_div(input int unsigned a, input int unsigned b);
        int unsigned q;
        q = (a + b - 1) / b;
        return (q == 0) ? 1 : q;
    endfunction

    // Expected schedule, in cycles counted from reset release
    localparam int unsigned SC  = ST_US * MHZ;
    localparam int unsigned TP  = up_div(RP_NS * MHZ, 1000);
    localparam int unsigned TC  = up_div(RC_NS * MHZ, 1000);
    localparam int unsigned P   = SC + 1;
    localparam int unsigned R0  = P + TP;
    localparam int unsigned M   = R0 + NREF * TC;
    localparam int unsigned D   = M + RSC;
    localparam logic [AW-1:0] MODE_EXP = 13'h032;   // CL=3, sequential, BL=4 code 2
    localparam logic [AW-1:0] PRE_EXP  = 13'h400;   // bit 10

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdram_bringup #(
        .CLK_MHZ (MHZ), .STABLE_US (ST_US), .TRP_NS (RP_NS), .TRC_NS (RC_NS),
        .TRSC_CLK (RSC), .REFRESH_CNT (NREF), .BURST_LEN (BL), .BURST_INTLV (1'b0),
        .CAS_LAT (CL), .ADDR_W (AW), .BANK_W (BW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .init_done (init_done)
    );

    function automatic logic [3:0] exp_cmd(input int unsigned n);
        if (n == P) return 4'b0010;
        if (n >= R0 && n < M && ((n - R0) % TC) == 0) return 4'b0001;
        if (n == M) return 4'b0000;
        return 4'b0111;
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int unsigned n);
        if (n == P) return PRE_EXP;
        if (n == M) return MODE_EXP;
        return '0;
    endfunction

    function automatic string tag_of(input int unsigned n);
        if (n < P) return "R2";
        if (n == P) return "R3";
        if (n == R0) return "R4";
        if (n < M) return "R5";
        if (n == M) return "R6";
        if (n >= D) return "R8";
        return "R9";
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_reset_state(input string req);
        chk(cke == 1'b1, req, 32'(cke), 32'd1);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, req, 32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
        chk(addr == '0 && ba == '0, req, 32'({ba, addr}), 32'd0);
        chk(init_done == 1'b0, req, 32'(init_done), 32'd0);
    endtask

    // Release reset, follow the schedule up to abort_at (0 = full run), then reset again
    task automatic run_seq(input int unsigned abort_at, input bit restarted);
        int unsigned first_cmd = 0;
        int unsigned hold;
        logic [3:0] c;
        rst_n = 1'b1;
        for (int unsigned n = 1; n <= D + 6; n++) begin
            @(posedge clk);
            @(negedge clk);
            c = {cs_n, ras_n, cas_n, we_n};
            chk(c == exp_cmd(n), tag_of(n), 32'(c), 32'(exp_cmd(n)));
            chk(cke == 1'b1, "R9", 32'(cke), 32'd1);
            chk(init_done == (n >= D), "R8", 32'(init_done), 32'(n >= D));
            if (exp_cmd(n) != 4'b0111) begin
                chk(addr == exp_addr(n), (n == M) ? "R7" : tag_of(n), 32'(addr), 32'(exp_addr(n)));
                chk(ba == '0, tag_of(n), 32'(ba), 32'd0);
            end
            if (first_cmd == 0 && c != 4'b0111) first_cmd = n;
            if (abort_at != 0 && n == abort_at) break;
        end
        if (restarted && (abort_at == 0 || abort_at >= P))
            chk(first_cmd == P, "R10", first_cmd, P);
        rst_n = 1'b0;
        hold = 1 + $urandom_range(5);
        repeat (hold) @(posedge clk);
        @(negedge clk);
        chk_reset_state((abort_at == 0) ? "R1" : "R10");
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_reset_state("R1");
        run_seq(0, 1'b0);
        run_seq(SC, 1'b1);                       // abort on the last quiet cycle
        run_seq(R0 + 3 * TC, 1'b1);              // abort in the refresh train
        run_seq(M + 1, 1'b1);                    // abort during mode-register recovery
        run_seq(1 + $urandom_range(D - 2), 1'b1);
        run_seq(1 + $urandom_range(D - 2), 1'b1);
        run_seq(0, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL R8 watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule